// File: doc/BRIEF.md
# Row-Buffered Self-Programming Controller for Instruction Memory

The block lets running software rewrite its own instruction store one row at a time. The store is an internal array of 24-bit words grouped into rows of `ROW_WORDS` words. Several rows form a panel, and every panel owns a row-wide staging buffer. Software first fills a staging buffer with table writes. Each word takes two of them: one for the low 16 bits, then one for the high 8 bits. The words go in strictly ascending order, starting from a row-aligned address. Software then arms the block and starts either a row erase or a row program.

A small register file sits on a 16-bit register bus. It holds a control word, the low and high halves of a 24-bit word address, and a write-only key register. Arming takes the key values 0x0055 and 0x00AA on back-to-back register writes. The control write that carries the start bit must follow them directly. When an operation starts, the sequencer spends `BUSY_CYCLES` cycles in an erase or program state with `busy` high. It updates the whole row at the edge where `busy` falls.

Sequencer states are SQ_IDLE, SQ_KEY1 (first key seen), SQ_ARMED (both keys seen), SQ_ERASE and SQ_PROG. The transitions are:
- IDLE/KEY1/ARMED to KEY1 on key 0x0055.
- KEY1 to ARMED on key 0x00AA.
- ARMED to ERASE or PROG on a control write with the start bit set.
- Any other register write in IDLE, KEY1 or ARMED leads to IDLE.
- ERASE/PROG to IDLE when the busy count expires.

Top module: `rowprog_ctrl`

## Requirements
- R1: After reset `busy` is 0, every register reads 0, no table write has been acknowledged, and every array word reads 0xFFFFFF.
- R2: The key register (select 3) always reads 0x0000.
- R3: An operation starts only on a control write with start bit 0 set, and only when that write directly follows register writes of 0x0055 and then 0x00AA to the key register. Repeated 0x0055 writes keep the first key. A control write without the start bit disarms the block.
- R4: Any other register write between 0x0055 and 0x00AA, or between 0x00AA and the control write, cancels the unlock.
- R5: A start request without a valid unlock starts nothing and sets the error bit (control bit 2). A control write without start clears the error bit, and so does an accepted start.
- R6: `busy` and control bit 3 are high for exactly `BUSY_CYCLES` cycles, beginning at the edge that accepts the start. Start bit 0 reads 1 while busy and 0 after. Control bit 1 (1 = program, 0 = erase) keeps the last written value.
- R7: Erase sets all words of the target row to 0xFFFFFF and leaves other rows unchanged.
- R8: Program copies the target panel's staging buffer into the target row. Unloaded words are 0xFFFFFF. The buffer then returns to all-ones with its fill position at 0.
- R9: A table write is accepted only if its word index (address bits 4:0) equals the buffer's fill position. A low half (`tbl_hi`=0) is accepted only before the high half, and the fill position advances after the high half. The first accepted index is therefore 0. Writes out of order, or writes to a full buffer, are dropped.
- R10: `tbl_ack` is high for one cycle, two edges after the edge that samples an accepted `tbl_wr`, and stays low for a dropped write.
- R11: Every table write made while idle loads all 24 address bits into the address registers (select 1: bits 15:0, select 2: bits 23:16 in data bits 7:0). Direct register writes change them as well. The target row is address bits 7:5.
- R12: While `busy` is high, table writes and register writes have no effect.
- R13: A panel is `PANEL_ROWS` rows, selected by row bits above the panel row index. Each panel has its own staging buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 address low, 2 address high, 3 key |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| tbl_wr | input | 1 | Table write strobe |
| tbl_hi | input | 1 | 0 = low 16 bits, 1 = high 8 bits |
| tbl_addr | input | 24 | Word address of the table write |
| tbl_data | input | 16 | Table write data |
| tbl_ack | output | 1 | Accepted table write completed |
| busy | output | 1 | Erase or program in progress |
| rd_addr | input | MEM_AW | Array read address |
| rd_data | output | 24 | Array read data (combinational) |

## Verification
Register and array reads are combinational, so the bench samples them at the falling edge after the edge that changed them. `busy` is sampled at the falling edge right after the accepting control write and is counted edge by edge until it drops. `tbl_ack` is expected low one falling edge after the strobe edge and high at the next one. Array contents are compared only after `busy` has been seen low, because the row changes on the same edge where `busy` falls.

// File: rtl/rowprog_pkg.sv
package rowprog_pkg;
    localparam int WORD_W = 24;
    localparam int LO_W   = 16;
    localparam int HI_W   = WORD_W - LO_W;
    localparam int ADDR_W = 24;
    localparam int BUS_W  = 16;

    localparam logic [1:0] SEL_CTRL    = 2'd0;
    localparam logic [1:0] SEL_ADDR_LO = 2'd1;
    localparam logic [1:0] SEL_ADDR_HI = 2'd2;
    localparam logic [1:0] SEL_KEY     = 2'd3;

    localparam int CTL_START = 0;
    localparam int CTL_PROG  = 1;
    localparam int CTL_ERR   = 2;
    localparam int CTL_BUSY  = 3;

    localparam logic [BUS_W-1:0] KEY_FIRST  = 16'h0055;
    localparam logic [BUS_W-1:0] KEY_SECOND = 16'h00AA;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_KEY1  = 3'd1,
        SQ_ARMED = 3'd2,
        SQ_ERASE = 3'd3,
        SQ_PROG  = 3'd4
    } seq_state_t;
endpackage

// File: rtl/rowprog_seq.sv
module rowprog_seq
    import rowprog_pkg::*;
#(
    parameter int BUSY_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic             busy,
    output logic             done_erase,
    output logic             done_prog,
    output logic             start_ok,
    output logic             start_bad
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ctl_wr, key_wr, want_start, want_prog, cnt_zero;

    assign ctl_wr     = reg_wr && (reg_sel == SEL_CTRL);
    assign key_wr     = reg_wr && (reg_sel == SEL_KEY);
    assign want_start = reg_wdata[CTL_START];
    assign want_prog  = reg_wdata[CTL_PROG];
    assign cnt_zero   = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SQ_IDLE, SQ_KEY1, SQ_ARMED: begin
                if (reg_wr) begin
                    state_d = SQ_IDLE;
                    if (key_wr && reg_wdata == KEY_FIRST) begin
                        state_d = SQ_KEY1;
                    end else if (key_wr && reg_wdata == KEY_SECOND && state_q == SQ_KEY1) begin
                        state_d = SQ_ARMED;
                    end else if (ctl_wr && want_start && state_q == SQ_ARMED) begin
                        state_d = want_prog ? SQ_PROG : SQ_ERASE;
                        cnt_d   = CNT_W'(BUSY_CYCLES - 1);
                    end
                end
            end
            SQ_ERASE, SQ_PROG: begin
                if (cnt_zero) begin
                    state_d = SQ_IDLE;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_comb begin
        busy       = 1'b0;
        done_erase = 1'b0;
        done_prog  = 1'b0;
        start_ok   = 1'b0;
        start_bad  = 1'b0;
        unique case (state_q)
            SQ_ERASE: begin
                busy       = 1'b1;
                done_erase = cnt_zero;
            end
            SQ_PROG: begin
                busy      = 1'b1;
                done_prog = cnt_zero;
            end
            SQ_ARMED: begin
                start_ok = ctl_wr && want_start;
            end
            SQ_IDLE, SQ_KEY1: begin
                start_bad = ctl_wr && want_start;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    // run-length counter for the busy window check
    logic [CNT_W:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    // R3
    unlock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(state_q) == SQ_ARMED);

    // R6
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_q < (CNT_W+1)'(BUSY_CYCLES));

    // R6
    busy_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(run_q) == (CNT_W+1)'(BUSY_CYCLES - 1));
endmodule

// File: rtl/rowprog_latch.sv
module rowprog_latch
    import rowprog_pkg::*;
#(
    parameter int ROW_WORDS = 32,
    parameter int IDX_W     = $clog2(ROW_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        wr_hi,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [LO_W-1:0]             wr_data,
    input  logic                        clr,
    output logic [ROW_WORDS*WORD_W-1:0] row_flat,
    output logic                        acc
);
    localparam int PTR_W = $clog2(ROW_WORDS + 1);

    logic [WORD_W-1:0] words_q [ROW_WORDS];
    logic [PTR_W-1:0]  ptr_q;
    logic              half_q;

    assign acc = wr_en && !clr && (ptr_q < PTR_W'(ROW_WORDS))
              && (PTR_W'(wr_idx) == ptr_q) && (wr_hi == half_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ROW_WORDS; i++) words_q[i] <= '1;
            ptr_q  <= '0;
            half_q <= 1'b0;
        end else if (clr) begin
            for (int i = 0; i < ROW_WORDS; i++) words_q[i] <= '1;
            ptr_q  <= '0;
            half_q <= 1'b0;
        end else if (acc) begin
            if (!wr_hi) begin
                words_q[wr_idx][LO_W-1:0] <= wr_data;
                half_q                    <= 1'b1;
            end else begin
                words_q[wr_idx][WORD_W-1:LO_W] <= wr_data[HI_W-1:0];
                half_q                         <= 1'b0;
                ptr_q                          <= ptr_q + 1'b1;
            end
        end
    end

    for (genvar w = 0; w < ROW_WORDS; w++) begin : g_flat
        assign row_flat[w*WORD_W +: WORD_W] = words_q[w];
    end

    // R9
    fill_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PTR_W'(ROW_WORDS));

    // R9
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && !clr) |=> $stable(ptr_q) && $stable(half_q));
endmodule

// File: rtl/rowprog_array.sv
module rowprog_array
    import rowprog_pkg::*;
#(
    parameter int NUM_ROWS  = 8,
    parameter int ROW_WORDS = 32,
    parameter int ROW_BITS  = $clog2(NUM_ROWS),
    parameter int MEM_AW    = $clog2(NUM_ROWS * ROW_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        erase_en,
    input  logic                        prog_en,
    input  logic [ROW_BITS-1:0]         row_sel,
    input  logic [ROW_WORDS*WORD_W-1:0] row_flat,
    input  logic [MEM_AW-1:0]           rd_addr,
    output logic [WORD_W-1:0]           rd_data
);
    localparam int DEPTH = NUM_ROWS * ROW_WORDS;

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (erase_en) begin
            for (int i = 0; i < ROW_WORDS; i++) mem_q[int'(row_sel) * ROW_WORDS + i] <= '1;
        end else if (prog_en) begin
            for (int i = 0; i < ROW_WORDS; i++)
                mem_q[int'(row_sel) * ROW_WORDS + i] <= row_flat[i*WORD_W +: WORD_W];
        end
    end

    assign rd_data = mem_q[rd_addr];

    // R7
    erase_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> (mem_q[int'($past(row_sel)) * ROW_WORDS] == '1)
                  && (mem_q[int'($past(row_sel)) * ROW_WORDS + ROW_WORDS - 1] == '1));
endmodule

// File: rtl/rowprog_ctrl.sv
module rowprog_ctrl
    import rowprog_pkg::*;
#(
    parameter int NUM_ROWS    = 8,
    parameter int ROW_WORDS   = 32,
    parameter int PANEL_ROWS  = 4,
    parameter int BUSY_CYCLES = 16,
    parameter int MEM_AW      = $clog2(NUM_ROWS * ROW_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    input  logic              tbl_wr,
    input  logic              tbl_hi,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic [LO_W-1:0]   tbl_data,
    output logic              tbl_ack,
    output logic              busy,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int IDX_W      = $clog2(ROW_WORDS);
    localparam int ROW_BITS   = $clog2(NUM_ROWS);
    localparam int PANEL_BITS = $clog2(PANEL_ROWS);
    localparam int NUM_PANELS = NUM_ROWS / PANEL_ROWS;
    localparam int PSEL_W     = (NUM_PANELS > 1) ? $clog2(NUM_PANELS) : 1;

    function automatic logic [ROW_BITS-1:0] row_of(input logic [ADDR_W-1:0] a);
        return a[IDX_W +: ROW_BITS];
    endfunction

    function automatic logic [PSEL_W-1:0] panel_of(input logic [ROW_BITS-1:0] r);
        logic [ROW_BITS-1:0] sh;
        sh = r >> PANEL_BITS;
        return sh[PSEL_W-1:0];
    endfunction

    // sequencer
    logic done_erase, done_prog, start_ok, start_bad;

    rowprog_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .busy       (busy),
        .done_erase (done_erase),
        .done_prog  (done_prog),
        .start_ok   (start_ok),
        .start_bad  (start_bad)
    );

    // table write staging: sampled in cycle one, committed in cycle two
    logic              tw_v, tw_hi;
    logic [ADDR_W-1:0] tw_addr;
    logic [LO_W-1:0]   tw_data;
    logic              commit_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tw_v    <= 1'b0;
            tw_hi   <= 1'b0;
            tw_addr <= '0;
            tw_data <= '0;
        end else begin
            tw_v <= tbl_wr && !busy;
            if (tbl_wr && !busy) begin
                tw_hi   <= tbl_hi;
                tw_addr <= tbl_addr;
                tw_data <= tbl_data;
            end
        end
    end

    assign commit_en = tw_v && !busy;

    // control and address registers
    logic              start_q, prog_q, err_q;
    logic [ADDR_W-1:0] addr_q;
    logic              reg_go;

    assign reg_go = reg_wr && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            prog_q  <= 1'b0;
            err_q   <= 1'b0;
            addr_q  <= '0;
        end else begin
            if (done_erase || done_prog) start_q <= 1'b0;
            if (reg_go && reg_sel == SEL_CTRL) begin
                prog_q <= reg_wdata[CTL_PROG];
                if (start_ok) begin
                    start_q <= 1'b1;
                    err_q   <= 1'b0;
                end else if (start_bad) begin
                    err_q <= 1'b1;
                end else begin
                    err_q <= 1'b0;
                end
            end
            if (reg_go && reg_sel == SEL_ADDR_LO) addr_q[LO_W-1:0] <= reg_wdata;
            if (reg_go && reg_sel == SEL_ADDR_HI) addr_q[ADDR_W-1:LO_W] <= reg_wdata[ADDR_W-LO_W-1:0];
            if (commit_en) addr_q <= tw_addr;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_CTRL: begin
                reg_rdata[CTL_START] = start_q;
                reg_rdata[CTL_PROG]  = prog_q;
                reg_rdata[CTL_ERR]   = err_q;
                reg_rdata[CTL_BUSY]  = busy;
            end
            SEL_ADDR_LO: reg_rdata = addr_q[LO_W-1:0];
            SEL_ADDR_HI: reg_rdata = BUS_W'(addr_q[ADDR_W-1:LO_W]);
            SEL_KEY:     reg_rdata = '0;
            default:     reg_rdata = '0;
        endcase
    end

    // per-panel staging buffers
    logic [ROW_BITS-1:0]         tgt_row;
    logic [PSEL_W-1:0]           tgt_panel, tw_panel;
    logic [ROW_WORDS*WORD_W-1:0] bank_row [NUM_PANELS];
    logic [NUM_PANELS-1:0]       bank_acc;

    assign tgt_row   = row_of(addr_q);
    assign tgt_panel = panel_of(tgt_row);
    assign tw_panel  = panel_of(row_of(tw_addr));

    for (genvar p = 0; p < NUM_PANELS; p++) begin : g_bank
        rowprog_latch #(.ROW_WORDS(ROW_WORDS), .IDX_W(IDX_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (commit_en && (tw_panel == PSEL_W'(p))),
            .wr_hi    (tw_hi),
            .wr_idx   (tw_addr[IDX_W-1:0]),
            .wr_data  (tw_data),
            .clr      (done_prog && (tgt_panel == PSEL_W'(p))),
            .row_flat (bank_row[p]),
            .acc      (bank_acc[p])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_ack <= 1'b0;
        else        tbl_ack <= commit_en && (|bank_acc);
    end

    rowprog_array #(
        .NUM_ROWS  (NUM_ROWS),
        .ROW_WORDS (ROW_WORDS),
        .ROW_BITS  (ROW_BITS),
        .MEM_AW    (MEM_AW)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .erase_en (done_erase),
        .prog_en  (done_prog),
        .row_sel  (tgt_row),
        .row_flat (bank_row[tgt_panel]),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    // R6
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !start_q);

    // R12
    busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr_q));

    // R10
    ack_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_ack |-> $past(tbl_wr, 2));

    // R5
    err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !busy && reg_sel == SEL_CTRL && reg_wdata[CTL_START] && !start_ok) |=> err_q && !busy);
endmodule

// File: tb/rowprog_ctrl_test.sv
module rowprog_ctrl_test;
    localparam int NROWS = 8;
    localparam int BUSY  = 16;
    localparam int AW    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  wr_sel = 2'd0, rd_sel = 2'd0, reg_sel;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic        tbl_wr = 1'b0, tbl_hi = 1'b0, tbl_ack, busy;
    logic [23:0] tbl_addr = '0;
    logic [15:0] tbl_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [23:0] rd_data;

    int vectors = 0;
    int errors  = 0;
    bit ended   = 1'b0;

    assign reg_sel = reg_wr ? wr_sel : rd_sel;

    always #5 clk = ~clk;

    rowprog_ctrl #(.NUM_ROWS(NROWS), .ROW_WORDS(32), .PANEL_ROWS(4), .BUSY_CYCLES(BUSY)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tbl_wr(tbl_wr), .tbl_hi(tbl_hi), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data), .tbl_ack(tbl_ack), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // scoreboard queues
    bit          q_mem [$];
    logic [15:0] q_a   [$];
    logic [23:0] q_v   [$];
    string       q_tag [$];
    bit          mon_active = 1'b0;

    function automatic logic [23:0] pat(input int row, input int i);
        return {8'(row) ^ 8'h3C, 8'(i), 8'(i * 7 + row)};
    endfunction

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic exp_mem(input int addr, input logic [23:0] v, input string tag);
        q_mem.push_back(1'b1); q_a.push_back(16'(addr)); q_v.push_back(v); q_tag.push_back(tag);
    endtask

    task automatic exp_reg(input logic [1:0] sel, input logic [15:0] v, input string tag);
        q_mem.push_back(1'b0); q_a.push_back(16'(sel)); q_v.push_back(24'(v)); q_tag.push_back(tag);
    endtask

    task automatic drain();
        wait (q_mem.size() == 0 && !mon_active);
    endtask

    // monitor: pops expected items and compares at the falling edge
    initial begin
        forever begin
            wait (q_mem.size() > 0);
            mon_active = 1'b1;
            @(negedge clk);
            if (q_mem[0]) rd_addr = AW'(q_a[0]);
            else          rd_sel  = q_a[0][1:0];
            #1;
            if (q_mem[0]) check(q_tag[0], rd_data, q_v[0]);
            else          check(q_tag[0], 24'(reg_rdata), q_v[0]);
            void'(q_mem.pop_front()); void'(q_a.pop_front());
            void'(q_v.pop_front());   void'(q_tag.pop_front());
            mon_active = 1'b0;
        end
    end

    task automatic reg_write(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; wr_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic tbl_write(input bit hi, input int addr, input logic [15:0] d,
                             input bit exp_ack, input string tag);
        @(negedge clk);
        tbl_wr = 1'b1; tbl_hi = hi; tbl_addr = 24'(addr); tbl_data = d;
        @(negedge clk);
        tbl_wr = 1'b0;
        check(tag, 24'(tbl_ack), 24'd0);
        @(negedge clk);
        check(tag, 24'(tbl_ack), 24'(exp_ack));
    endtask

    task automatic load_row(input int row);
        for (int i = 0; i < 32; i++) begin
            logic [23:0] w;
            w = pat(row, i);
            tbl_write(1'b0, row * 32 + i, w[15:0], 1'b1, "R10 low ack");
            tbl_write(1'b1, row * 32 + i, {8'h00, w[23:16]}, 1'b1, "R10 high ack");
        end
    endtask

    task automatic unlock_start(input logic [15:0] ctl);
        reg_write(2'd3, 16'h0055);
        reg_write(2'd3, 16'h00AA);
        reg_write(2'd0, ctl);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", 24'(busy), 24'd0);
        check("R1 ack", 24'(tbl_ack), 24'd0);
        exp_reg(2'd0, 16'h0000, "R1 ctrl");
        exp_reg(2'd1, 16'h0000, "R1 addr lo");
        exp_reg(2'd2, 16'h0000, "R1 addr hi");
        exp_reg(2'd3, 16'h0000, "R2 key");
        exp_mem(0, 24'hFFFFFF, "R1 mem first");
        exp_mem(255, 24'hFFFFFF, "R1 mem last");
        drain();

        // R9 / R10: full ordered load of row 2, then overflow dropped
        load_row(2);
        tbl_write(1'b0, 64, 16'h1111, 1'b0, "R9 full buffer drop");
        exp_reg(2'd1, 16'h0040, "R11 table captures addr lo");
        exp_reg(2'd2, 16'h0000, "R11 addr hi");
        drain();
        reg_write(2'd1, 16'h0040);

        // R3 / R6 / R8 program row 2, count busy
        unlock_start(16'h0003);
        begin
            int n = 0;
            while (busy) begin n++; @(negedge clk); end
            check("R6 busy length", 24'(n), 24'(BUSY));
        end
        exp_reg(2'd0, 16'h0002, "R6 start cleared, prog kept");
        for (int i = 0; i < 32; i += 7) exp_mem(64 + i, pat(2, i), "R8 programmed word");
        exp_mem(64 + 31, pat(2, 31), "R8 last word");
        exp_mem(32, 24'hFFFFFF, "R8 row 1 untouched");
        exp_mem(96, 24'hFFFFFF, "R8 row 3 untouched");
        drain();

        // R13: one word into panel 0, full row 6 into panel 1
        tbl_write(1'b0, 64, 16'hBEEF, 1'b1, "R13 panel0 low");
        tbl_write(1'b1, 64, 16'h0012, 1'b1, "R13 panel0 high");
        load_row(6);
        unlock_start(16'h0003);
        wait_idle();
        exp_mem(192, pat(6, 0), "R13 row6 word0");
        exp_mem(192 + 17, pat(6, 17), "R13 row6 word17");
        exp_mem(192 + 31, pat(6, 31), "R13 row6 word31");
        drain();

        // R9 ordering rules on panel 0 (fill position 1)
        tbl_write(1'b0, 66, 16'h2222, 1'b0, "R9 skipped index drop");
        tbl_write(1'b1, 65, 16'h0033, 1'b0, "R9 high before low drop");
        tbl_write(1'b0, 65, 16'hCAFE, 1'b1, "R9 in-order low");
        tbl_write(1'b1, 65, 16'h0044, 1'b1, "R9 in-order high");
        reg_write(2'd1, 16'h0020);
        exp_reg(2'd1, 16'h0020, "R11 direct addr write");
        drain();
        unlock_start(16'h0003);
        exp_reg(2'd0, 16'h000B, "R6 start and busy bits during op");
        drain();
        tbl_write(1'b0, 66, 16'h5555, 1'b0, "R12 table write while busy");
        reg_write(2'd1, 16'h1234);
        wait_idle();
        exp_reg(2'd1, 16'h0020, "R12 addr write while busy ignored");
        exp_mem(32, 24'h12BEEF, "R8 partial word0");
        exp_mem(33, 24'h44CAFE, "R8 partial word1");
        exp_mem(34, 24'hFFFFFF, "R8 partial unloaded word");
        exp_mem(63, 24'hFFFFFF, "R8 partial last word");
        drain();

        // R7 erase row 2 via direct address
        reg_write(2'd1, 16'h0040);
        unlock_start(16'h0001);
        wait_idle();
        exp_reg(2'd0, 16'h0000, "R7 ctrl after erase");
        exp_mem(64, 24'hFFFFFF, "R7 erased word0");
        exp_mem(95, 24'hFFFFFF, "R7 erased word31");
        exp_mem(192 + 5, pat(6, 5), "R7 other row kept");
        exp_mem(32, 24'h12BEEF, "R7 row1 kept");
        drain();

        // R4 interrupted unlock
        reg_write(2'd3, 16'h0055);
        reg_write(2'd2, 16'h0000);
        reg_write(2'd3, 16'h00AA);
        reg_write(2'd0, 16'h0003);
        check("R4 no busy after broken unlock", 24'(busy), 24'd0);
        exp_reg(2'd0, 16'h0006, "R4 error set");
        drain();
        reg_write(2'd0, 16'h0000);
        exp_reg(2'd0, 16'h0000, "R5 error cleared by plain ctrl write");
        drain();

        // R5 start with no unlock
        reg_write(2'd0, 16'h0001);
        check("R5 no busy", 24'(busy), 24'd0);
        exp_reg(2'd0, 16'h0004, "R5 error bit");
        exp_mem(64, 24'hFFFFFF, "R5 row unchanged");
        drain();

        // R3 disarm by ctrl write without start
        reg_write(2'd3, 16'h0055);
        reg_write(2'd3, 16'h00AA);
        reg_write(2'd0, 16'h0000);
        reg_write(2'd0, 16'h0001);
        check("R3 disarmed start ignored", 24'(busy), 24'd0);
        exp_reg(2'd0, 16'h0004, "R3 disarmed error");
        drain();

        // R3 repeated first key still arms; erase row 6
        reg_write(2'd1, 16'h00C0);
        reg_write(2'd3, 16'h0055);
        reg_write(2'd3, 16'h0055);
        reg_write(2'd3, 16'h00AA);
        reg_write(2'd0, 16'h0001);
        check("R3 repeated key starts", 24'(busy), 24'd1);
        wait_idle();
        exp_reg(2'd0, 16'h0000, "R5 error cleared by valid start");
        exp_mem(192, 24'hFFFFFF, "R3 row6 erased");
        exp_mem(32, 24'h12BEEF, "R7 row1 still kept");
        exp_reg(2'd3, 16'h0000, "R2 key reads zero");
        drain();

        finish_run();
    end
endmodule